// File: doc/BRIEF.md
# Systolic Insertion Sorter

This block sorts a block of wide keys as they stream in, one key per clock. It is a linear chain of identical compare-and-hold cells. Every key is 128 bits, presented as an upper 64-bit half and a lower 64-bit half, and compared as one unsigned number whose upper half is the more significant. A key that enters a cell that already holds a key is compared with it. The cell keeps the larger of the two and passes the smaller one on to the next cell on the following clock. After the block closes, the chain settles and then shifts its contents out of the first cell, largest key first.

A block closes on a key that carries the end-of-block flag. It also closes on the key that fills the last free cell, whichever comes first. From the close until the final sorted key has left, the input is not ready and offered keys are not taken. A long list is sorted by feeding it as a sequence of such blocks. The result is several independently sorted runs that a later stage merges.

Top module: `keychain_sorter`

## Requirements
- R1: The keys of a block leave in non-increasing order, largest first. Keys compare as unsigned 128-bit numbers whose upper half (`in_hi`) is the more significant.
- R2: Each block produces exactly as many output beats as keys it accepted. `out_last` is high on the final beat of the block and on no other beat.
- R3: When two keys differ in their upper halves, the one with the larger upper half comes out first, whatever their lower halves hold.
- R4: Duplicate keys are all kept. A block of equal keys comes out as that many copies of the key.
- R5: `in_ready` is low from the clock edge that accepts a block's closing key until the edge after its final output beat. It is high at all other times, and `out_valid` is never high while `in_ready` is high.
- R6: A block that reaches NUM_CELLS keys without a flagged key closes on its NUM_CELLS-th key. The next key offered starts a new block.
- R7: The final output beat of a block appears no later than 2*NUM_CELLS clock cycles after the edge that accepts the block's closing key.
- R8: After reset, `out_valid` is low and `in_ready` is high.
- R9: A key offered while `in_ready` is low is not taken. It never appears on the output and does not alter the sorted run being emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A key is offered |
| in_ready | output | 1 | The sorter takes the offered key on this edge |
| in_hi | input | 64 | Upper (more significant) half of the key |
| in_lo | input | 64 | Lower half of the key |
| in_last | input | 1 | The offered key closes the block |
| out_valid | output | 1 | A sorted key is on the output |
| out_hi | output | 64 | Upper half of the sorted key |
| out_lo | output | 64 | Lower half of the sorted key |
| out_last | output | 1 | This is the final key of the block |

## Verification
The sorter is tried with full random blocks, short blocks, and blocks already in ascending and in descending order. The ascending block makes every key displace the held keys and ripple the whole chain. The descending block makes each key travel to an empty cell. An all-equal block and a block whose upper halves run opposite to the lower halves separate tie handling and half priority from plain ordering. A run of keys with no flag checks the forced close at full capacity. Junk keys held on the input during every drain check that nothing is taken while the sorter is busy.

// File: rtl/ksort_pkg.sv
// Package: shared types and helpers for the systolic insertion sorter.
// Assumes keys are unsigned and compared as one packed vector.
package ksort_pkg;

    // Phase of the block currently in the sorter.
    typedef enum logic [1:0] {
        PH_FILL   = 2'd0,   // accepting keys of a block
        PH_SETTLE = 2'd1,   // waiting for keys still moving along the chain
        PH_DRAIN  = 2'd2    // shifting sorted keys out, largest first
    } phase_t;

endpackage

// File: rtl/ksort_cell.sv
// Module: one compare-and-hold cell of the sorting chain.
// In fill mode it keeps the larger of the held and the incoming key and
// forwards the smaller one a clock later. An empty cell takes the key and
// forwards nothing. On equal keys it keeps the held key and forwards the
// incoming one. In drain mode it loads the held key of its downstream
// neighbour, so the chain shifts toward cell 0.
// Assumes the drain input is only raised once no forwarded key is in flight.
module ksort_cell #(
    parameter int KEY_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             drain,
    input  logic             in_v,
    input  logic [KEY_W-1:0] in_k,
    input  logic             sh_v,
    input  logic [KEY_W-1:0] sh_k,
    output logic             hold_v,
    output logic [KEY_W-1:0] hold_k,
    output logic             fwd_v,
    output logic [KEY_W-1:0] fwd_k
);

    logic take_new;   // incoming key wins and replaces the held key

    // Purpose: decide whether the incoming key displaces the held one.
    always_comb begin
        take_new = in_v && (!hold_v || (in_k > hold_k));
    end

    // Purpose: hold / forward registers for fill and shift for drain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_v <= 1'b0;
            hold_k <= '0;
            fwd_v  <= 1'b0;
            fwd_k  <= '0;
        end else if (drain) begin
            hold_v <= sh_v;
            hold_k <= sh_k;
            fwd_v  <= 1'b0;
        end else if (in_v) begin
            if (!hold_v) begin
                hold_v <= 1'b1;
                hold_k <= in_k;
                fwd_v  <= 1'b0;
            end else if (take_new) begin
                hold_k <= in_k;
                fwd_k  <= hold_k;
                fwd_v  <= 1'b1;
            end else begin
                fwd_k  <= in_k;
                fwd_v  <= 1'b1;
            end
        end else begin
            fwd_v <= 1'b0;
        end
    end

endmodule

// File: rtl/ksort_ctrl.sv
// Module: block sequencing for the sorting chain.
// Counts keys of the open block and closes it on a flagged key or when the
// chain is full. It then waits until nothing is in flight and drains until
// the final beat. Also keeps guard counters for the block's assertions.
// Assumes out_valid / out_last come from the chain head during drain only.
module ksort_ctrl #(
    parameter int NUM_CELLS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_last,
    input  logic any_fwd,
    input  logic out_valid,
    input  logic out_last,
    output logic in_ready,
    output logic accept,
    output logic drain
);
    import ksort_pkg::*;

    localparam int CNT_W = $clog2(NUM_CELLS + 1);
    localparam int LAT_MAX = 2 * NUM_CELLS;
    localparam int LAT_W = $clog2(LAT_MAX + 2) + 1;

    phase_t           phase;
    logic [CNT_W-1:0] fill_cnt;   // keys taken into the open block
    logic [CNT_W-1:0] pend_cnt;   // keys taken but not yet emitted
    logic [LAT_W-1:0] lat_cnt;    // edges since the block closed
    logic             close_blk;

    // Purpose: handshake and block-close decode.
    always_comb begin
        in_ready  = (phase == PH_FILL);
        accept    = in_valid && in_ready;
        close_blk = accept && (in_last || (fill_cnt == CNT_W'(NUM_CELLS - 1)));
        drain     = (phase == PH_DRAIN);
    end

    // Purpose: phase sequencing and fill count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_FILL;
            fill_cnt <= '0;
        end else begin
            case (phase)
                PH_FILL: begin
                    if (close_blk) begin
                        phase    <= PH_SETTLE;
                        fill_cnt <= '0;
                    end else if (accept) begin
                        fill_cnt <= fill_cnt + 1'b1;
                    end
                end
                PH_SETTLE: begin
                    if (!any_fwd) phase <= PH_DRAIN;
                end
                PH_DRAIN: begin
                    if (out_last) phase <= PH_FILL;
                end
                default: phase <= PH_FILL;
            endcase
        end
    end

    // Purpose: keys owed to the output (guards the beat count).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_cnt <= '0;
        end else if (accept) begin
            pend_cnt <= pend_cnt + 1'b1;
        end else if (out_valid) begin
            pend_cnt <= pend_cnt - 1'b1;
        end
    end

    // Purpose: edges elapsed since the block closed (guards latency).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_cnt <= '0;
        end else if (close_blk) begin
            lat_cnt <= LAT_W'(1);
        end else if (phase != PH_FILL && lat_cnt != {LAT_W{1'b1}}) begin
            lat_cnt <= lat_cnt + 1'b1;
        end
    end

    // R5: the output never runs while new keys are being taken.
    a_r5_no_out_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R2: the flagged final beat is the last key owed.
    a_r2_last_is_final: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> (pend_cnt == CNT_W'(1)));

    // R2: no beat appears without a key owed.
    a_r2_no_extra_beat: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (pend_cnt != '0));

    // R6: a block never holds more keys than there are cells.
    a_r6_cap_fill: assert property (@(posedge clk) disable iff (!rst_n)
        pend_cnt <= CNT_W'(NUM_CELLS));

    // R7: the final beat lands within twice the cell count.
    a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> (lat_cnt <= LAT_W'(LAT_MAX)));

endmodule

// File: rtl/keychain_sorter.sv
// Module: top of the systolic insertion sorter.
// Chains NUM_CELLS compare-and-hold cells. Cell 0 takes the input key,
// cell i takes what cell i-1 forwards, and during drain each cell loads
// the held key of cell i+1. The output is the held key of cell 0.
// Assumes a block of at most NUM_CELLS keys (enforced by the controller).
module keychain_sorter #(
    parameter int NUM_CELLS = 8,
    parameter int HALF_W    = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [HALF_W-1:0] in_hi,
    input  logic [HALF_W-1:0] in_lo,
    input  logic              in_last,
    output logic              out_valid,
    output logic [HALF_W-1:0] out_hi,
    output logic [HALF_W-1:0] out_lo,
    output logic              out_last
);

    localparam int KEY_W = 2 * HALF_W;

    logic             accept;
    logic             drain;
    logic             any_fwd;
    logic [KEY_W-1:0] hold_k [NUM_CELLS+1];
    logic             hold_v [NUM_CELLS+1];
    logic [KEY_W-1:0] fwd_k  [NUM_CELLS];
    logic [NUM_CELLS-1:0] fwd_v;

    // Purpose: empty slot beyond the chain tail, shifted in during drain.
    assign hold_k[NUM_CELLS] = '0;
    assign hold_v[NUM_CELLS] = 1'b0;

    for (genvar gi = 0; gi < NUM_CELLS; gi++) begin : g_cell
        logic [KEY_W-1:0] src_k;
        logic             src_v;
        logic             fv;

        if (gi == 0) begin : g_head
            // Purpose: the head cell is fed from the input port.
            assign src_k = {in_hi, in_lo};
            assign src_v = accept;
        end else begin : g_body
            // Purpose: later cells are fed by the upstream forward register.
            assign src_k = fwd_k[gi-1];
            assign src_v = fwd_v[gi-1];
        end

        ksort_cell #(.KEY_W(KEY_W)) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .drain  (drain),
            .in_v   (src_v),
            .in_k   (src_k),
            .sh_v   (hold_v[gi+1]),
            .sh_k   (hold_k[gi+1]),
            .hold_v (hold_v[gi]),
            .hold_k (hold_k[gi]),
            .fwd_v  (fv),
            .fwd_k  (fwd_k[gi])
        );
        assign fwd_v[gi] = fv;

        if (gi < NUM_CELLS - 1) begin : g_pair
            // R1: a settled neighbour never holds more than its upstream cell.
            a_r1_chain_order: assert property (@(posedge clk) disable iff (!rst_n)
                hold_v[gi+1] |-> (hold_k[gi] >= hold_k[gi+1]));
            // R2: occupied cells form one unbroken run from the head.
            a_r2_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
                hold_v[gi+1] |-> hold_v[gi]);
        end
    end

    // Purpose: any key still travelling along the chain.
    assign any_fwd = |fwd_v;

    // Purpose: output taken from the head cell while draining.
    always_comb begin
        out_valid = drain && hold_v[0];
        out_last  = out_valid && !hold_v[1];
        out_hi    = hold_k[0][KEY_W-1:HALF_W];
        out_lo    = hold_k[0][HALF_W-1:0];
    end

    ksort_ctrl #(.NUM_CELLS(NUM_CELLS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_last   (in_last),
        .any_fwd   (any_fwd),
        .out_valid (out_valid),
        .out_last  (out_last),
        .in_ready  (in_ready),
        .accept    (accept),
        .drain     (drain)
    );

    // R6: the tail cell never has to forward, so no key is lost.
    a_r6_tail_no_spill: assert property (@(posedge clk) disable iff (!rst_n)
        !fwd_v[NUM_CELLS-1]);

endmodule

// File: tb/sim_keychain_sorter.sv
module sim_keychain_sorter;

    localparam int CLK_PERIOD = 10;
    localparam int N = 8;
    localparam int HW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [HW-1:0] in_hi = '0;
    logic [HW-1:0] in_lo = '0;
    logic          in_last = 1'b0;
    logic          out_valid;
    logic [HW-1:0] out_hi;
    logic [HW-1:0] out_lo;
    logic          out_last;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 1'b0;

    logic [2*HW-1:0] pend_q[$];   // keys of the open block
    logic [2*HW-1:0] exp_q[$];    // sorted keys still to be emitted
    bit busy = 1'b0;
    int lat = 0;
    int fill = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    keychain_sorter #(.NUM_CELLS(N), .HALF_W(HW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_hi(in_hi), .in_lo(in_lo), .in_last(in_last),
        .out_valid(out_valid), .out_hi(out_hi), .out_lo(out_lo), .out_last(out_last)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [2*HW-1:0] act, input logic [2*HW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            check(1'b0, "R7", "watchdog expired", 0, 0);
            finish_up();
        end
    end

    // Reference model, compared at every falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) lat++;
            // R5: ready exactly when no block is pending.
            check(in_ready == !busy, "R5", "in_ready", in_ready, !busy);
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2", "unexpected beat", {out_hi, out_lo}, 0);
                end else begin
                    logic [2*HW-1:0] e;
                    e = exp_q.pop_front();
                    // R1 / R3 / R4: next key of the descending run.
                    check({out_hi, out_lo} == e, "R1", "sorted key", {out_hi, out_lo}, e);
                    // R2: flag only on the final beat.
                    check(out_last == (exp_q.size() == 0), "R2", "out_last",
                          out_last, exp_q.size() == 0);
                    if (exp_q.size() == 0) begin
                        // R7: bounded latency from the closing key.
                        check(lat <= 2*N, "R7", "latency", lat, 2*N);
                        busy = 1'b0;
                    end
                end
            end
            // R9: only keys offered while ready are recorded.
            if (in_valid && in_ready) begin
                pend_q.push_back({in_hi, in_lo});
                fill++;
                if (in_last || fill == N) begin
                    exp_q = pend_q;
                    exp_q.rsort();
                    pend_q.delete();
                    fill = 0;
                    busy = 1'b1;
                    lat = 0;
                end
            end
        end
    end

    task automatic put(input logic [2*HW-1:0] k, input bit last);
        in_valid = 1'b1;
        {in_hi, in_lo} = k;
        in_last = last;
        do @(negedge clk); while (!in_ready);
        @(posedge clk); #1;
        in_valid = 1'b0;
        in_last = 1'b0;
    endtask

    // R9: keep junk keys on the input for the whole drain.
    task automatic junk_until_ready();
        forever begin
            if (in_ready) break;
            in_valid = 1'b1;
            {in_hi, in_lo} = {$urandom, $urandom, $urandom, $urandom};
            in_last = $urandom_range(0, 1);
            @(posedge clk); #1;
        end
        in_valid = 1'b0;
        in_last = 1'b0;
    endtask

    function automatic logic [2*HW-1:0] rnd_key();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state.
        check(out_valid == 1'b0, "R8", "out_valid after reset", out_valid, 0);
        check(in_ready == 1'b1, "R8", "in_ready after reset", in_ready, 1);
        @(posedge clk); #1;

        // R1: full random block.
        for (int i = 0; i < N; i++) put(rnd_key(), i == N-1);
        junk_until_ready();
        // R1: short block of three.
        for (int i = 0; i < 3; i++) put(rnd_key(), i == 2);
        junk_until_ready();
        // R1: single key.
        put(rnd_key(), 1'b1);
        junk_until_ready();
        // R1: ascending input, every key ripples.
        for (int i = 0; i < N; i++) put({64'd0, 64'(i + 1)}, i == N-1);
        junk_until_ready();
        // R1: descending input.
        for (int i = 0; i < N; i++) put({64'd5, 64'(100 - i)}, i == N-1);
        junk_until_ready();
        // R4: all equal keys.
        for (int i = 0; i < 5; i++) put({64'hABCD, 64'h1234}, i == 4);
        junk_until_ready();
        // R4: mix of duplicates.
        for (int i = 0; i < 7; i++) put({64'(i % 3), 64'(i % 2)}, i == 6);
        junk_until_ready();
        // R3: upper half dominates an opposite lower half.
        for (int i = 0; i < 6; i++) put({64'(i), 64'(~i)}, i == 5);
        junk_until_ready();
        // R6: N + 2 keys with no flag until the last; closes at N.
        for (int i = 0; i < N + 2; i++) begin
            put(rnd_key(), i == N + 1);
            if (i == N - 1) junk_until_ready();
        end
        junk_until_ready();

        repeat (4) @(posedge clk);
        @(negedge clk);
        check(exp_q.size() == 0 && pend_q.size() == 0 && !busy, "R2",
              "all blocks emitted", exp_q.size(), 0);
        finish_up();
    end

endmodule